// File: doc/BRIEF.md
# Execute-Stage Operand Bypass and Load-Use Interlock

This block supplies bypass control for a five-stage, 32-bit in-order pipeline. For each of the two execute-stage operands it picks one of three values. The first is the register-file value read in decode. The second is the ALU result of the instruction one stage ahead, in the execute/memory register. The third is the write-back value of the instruction two stages ahead, in the memory/write-back register. That write-back value can be loaded data that has not yet been committed. Because of this, back-to-back ALU dependences run with no lost cycle. A load whose destination is needed by the very next instruction costs a single bubble.

The block tracks the register metadata of the instructions in the later stages. This metadata is the source fields, the destination, the write-enable, the load flag and the operand-use flags. The surrounding datapath presents the decoded fields of each new instruction, together with the register-file data and the two in-flight result values. In return it receives the two select codes, the two operands, a hold request for the PC and the fetch/decode register, and a no-op request for the decode/execute register. The no-op is inserted inside this block's own metadata pipeline. The same destination comparisons drive both the forwarding choice and the interlock.

Top module: `bypass_ctrl`

## Requirements
- R1: A synchronous, active-high reset clears all tracked stage state. Right after reset both select codes read 00 and neither `hold_front` nor `insert_nop` is asserted, whatever decode presents.
- R2: If an execute-stage source equals the destination of the instruction in EX/MEM, and that instruction writes a register, the select code for that operand is 10 and the operand equals `exm_alu`.
- R3: If an execute-stage source equals the destination of the register-writing instruction in MEM/WB, and R2 does not apply, the select code is 01 and the operand equals `mwb_data`.
- R4: If both EX/MEM and MEM/WB match the same source, EX/MEM wins and the select code is 10.
- R5: A source or destination of register 0 never forwards. The select stays 00 and the operand equals the register-file input for that operand.
- R6: A producer whose write-enable is low (for example a store) is never a forwarding source, even if its destination field matches.
- R7: The rs and rt operands get their select codes independently (00 register file, 10 EX/MEM, 01 MEM/WB; 11 never appears). A store's data operand, rt, follows the same rules.
- R8: An ALU instruction that depends on the one directly before it proceeds with no hold.
- R9: A load in ID/EX with a nonzero destination, followed in decode by an instruction that uses that register as rs or rt, raises `hold_front` and `insert_nop` for exactly one cycle. A no-op then enters ID/EX. When the consumer reaches execute, its operand selects MEM/WB (01).
- R10: There is no hold when the load's destination is register 0, when the decode instruction does not use the matching field, or when the fields do not match.
- R11: A consumer two instructions after a load proceeds with no hold and takes the loaded value from MEM/WB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_rs | input | 5 | Decode-stage first source register |
| dec_rt | input | 5 | Decode-stage second source register |
| dec_dst | input | 5 | Decode-stage destination register |
| dec_wr | input | 1 | Decode-stage instruction writes a register |
| dec_load | input | 1 | Decode-stage instruction is a load |
| dec_use_rs | input | 1 | Decode-stage instruction reads rs |
| dec_use_rt | input | 1 | Decode-stage instruction reads rt |
| rf_rs_data | input | DATA_W | Register-file value for the execute-stage rs operand |
| rf_rt_data | input | DATA_W | Register-file value for the execute-stage rt operand |
| exm_alu | input | DATA_W | ALU result held in EX/MEM |
| mwb_data | input | DATA_W | Write-back value held in MEM/WB (ALU result or loaded data) |
| sel_rs | output | 2 | Select code for rs |
| sel_rt | output | 2 | Select code for rt |
| opnd_rs | output | DATA_W | Chosen rs operand |
| opnd_rt | output | DATA_W | Chosen rt operand |
| hold_front | output | 1 | Freeze the PC and the fetch/decode register |
| insert_nop | output | 1 | Load a no-op into ID/EX in place of the decode instruction |

## Verification
The interlock outputs depend combinationally on the decode fields and the ID/EX state. The bench therefore samples `hold_front` and `insert_nop` one time step after it drives a new instruction, in the same cycle. Select codes and operands belong to an instruction once it has passed one register, into ID/EX. They are checked at the falling edge that follows the rising edge at which that instruction entered, and the operand data inputs are held steady during that time. On a load-use hold the same instruction is presented again on the next cycle. The bench then expects the hold to be gone and the bubble to forward nothing. The consumer's selects are checked one cycle later than they would otherwise be.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

    localparam int RA_W = 5;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_MWB = 2'b01,
        SEL_EXM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic [RA_W-1:0] rs;
        logic [RA_W-1:0] rt;
        logic [RA_W-1:0] dst;
        logic            wr;
        logic            ld;
        logic            use_rs;
        logic            use_rt;
    } stage_meta_t;

    // True when a producer stage would supply register src.
    function automatic logic produces(logic [RA_W-1:0] src, stage_meta_t p);
        return p.wr && (p.dst != '0) && (p.dst == src);
    endfunction

    // Newer stage first: EX/MEM beats MEM/WB.
    function automatic fwd_sel_e pick_src(logic [RA_W-1:0] src,
                                          stage_meta_t exm, stage_meta_t mwb);
        if (produces(src, exm)) return SEL_EXM;
        if (produces(src, mwb)) return SEL_MWB;
        return SEL_RF;
    endfunction

endpackage

// File: rtl/bypass_stage_regs.sv
module bypass_stage_regs
    import bypass_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  stage_meta_t dec_meta,
    input  logic        bubble,
    output stage_meta_t idex_q,
    output stage_meta_t exm_q,
    output stage_meta_t mwb_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idex_q <= '0;
            exm_q  <= '0;
            mwb_q  <= '0;
        end else begin
            idex_q <= bubble ? stage_meta_t'('0) : dec_meta;
            exm_q  <= idex_q;
            mwb_q  <= exm_q;
        end
    end
endmodule

// File: rtl/bypass_interlock.sv
module bypass_interlock
    import bypass_pkg::*;
(
    input  stage_meta_t dec_meta,
    input  stage_meta_t idex_q,
    output logic        load_use
);
    logic hit_rs, hit_rt;

    always_comb begin
        hit_rs   = dec_meta.use_rs && produces(dec_meta.rs, idex_q);
        hit_rt   = dec_meta.use_rt && produces(dec_meta.rt, idex_q);
        load_use = idex_q.ld && (hit_rs || hit_rt);
    end
endmodule

// File: rtl/bypass_pick.sv
module bypass_pick
    import bypass_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [RA_W-1:0]   src,
    input  stage_meta_t       exm,
    input  stage_meta_t       mwb,
    input  logic [DATA_W-1:0] rf_data,
    input  logic [DATA_W-1:0] exm_data,
    input  logic [DATA_W-1:0] mwb_data,
    output logic [1:0]        sel,
    output logic [DATA_W-1:0] opnd
);
    fwd_sel_e choice;

    always_comb begin
        choice = pick_src(src, exm, mwb);
        unique case (choice)
            SEL_EXM: opnd = exm_data;
            SEL_MWB: opnd = mwb_data;
            default: opnd = rf_data;
        endcase
    end

    assign sel = choice;
endmodule

// File: rtl/bypass_ctrl.sv
module bypass_ctrl
    import bypass_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RA_W-1:0]   dec_rs,
    input  logic [RA_W-1:0]   dec_rt,
    input  logic [RA_W-1:0]   dec_dst,
    input  logic              dec_wr,
    input  logic              dec_load,
    input  logic              dec_use_rs,
    input  logic              dec_use_rt,
    input  logic [DATA_W-1:0] rf_rs_data,
    input  logic [DATA_W-1:0] rf_rt_data,
    input  logic [DATA_W-1:0] exm_alu,
    input  logic [DATA_W-1:0] mwb_data,
    output logic [1:0]        sel_rs,
    output logic [1:0]        sel_rt,
    output logic [DATA_W-1:0] opnd_rs,
    output logic [DATA_W-1:0] opnd_rt,
    output logic              hold_front,
    output logic              insert_nop
);
    localparam int N_OPND = 2;

    stage_meta_t dec_meta, idex_q, exm_q, mwb_q;
    logic        load_use;

    logic [RA_W-1:0]   src_arr  [N_OPND];
    logic [DATA_W-1:0] rf_arr   [N_OPND];
    logic [DATA_W-1:0] opnd_arr [N_OPND];
    logic [1:0]        sel_arr  [N_OPND];

    always_comb begin
        dec_meta.rs     = dec_rs;
        dec_meta.rt     = dec_rt;
        dec_meta.dst    = dec_dst;
        dec_meta.wr     = dec_wr;
        dec_meta.ld     = dec_load;
        dec_meta.use_rs = dec_use_rs;
        dec_meta.use_rt = dec_use_rt;
    end

    bypass_stage_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .dec_meta (dec_meta),
        .bubble   (load_use),
        .idex_q   (idex_q),
        .exm_q    (exm_q),
        .mwb_q    (mwb_q)
    );

    bypass_interlock u_lock (
        .dec_meta (dec_meta),
        .idex_q   (idex_q),
        .load_use (load_use)
    );

    assign src_arr[0] = idex_q.rs;
    assign src_arr[1] = idex_q.rt;
    assign rf_arr[0]  = rf_rs_data;
    assign rf_arr[1]  = rf_rt_data;

    for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
        bypass_pick #(.DATA_W(DATA_W)) u_pick (
            .src      (src_arr[k]),
            .exm      (exm_q),
            .mwb      (mwb_q),
            .rf_data  (rf_arr[k]),
            .exm_data (exm_alu),
            .mwb_data (mwb_data),
            .sel      (sel_arr[k]),
            .opnd     (opnd_arr[k])
        );
    end

    assign sel_rs     = sel_arr[0];
    assign sel_rt     = sel_arr[1];
    assign opnd_rs    = opnd_arr[0];
    assign opnd_rt    = opnd_arr[1];
    assign hold_front = load_use;
    assign insert_nop = load_use;
endmodule

// File: rtl/bypass_ctrl_chk.sv
module bypass_ctrl_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        sel_rs,
    input logic [1:0]        sel_rt,
    input logic [DATA_W-1:0] opnd_rs,
    input logic [DATA_W-1:0] opnd_rt,
    input logic [DATA_W-1:0] rf_rs_data,
    input logic [DATA_W-1:0] rf_rt_data,
    input logic [DATA_W-1:0] exm_alu,
    input logic [DATA_W-1:0] mwb_data,
    input logic              hold_front,
    input logic              insert_nop,
    input logic [4:0]        idex_rs,
    input logic [4:0]        idex_rt,
    input logic              idex_wr,
    input logic              idex_ld
);
    AST_EXM_RS_VALUE: assert property (@(posedge clk) disable iff (rst) sel_rs == 2'b10 |-> opnd_rs == exm_alu); // R2
    AST_EXM_RT_VALUE: assert property (@(posedge clk) disable iff (rst) sel_rt == 2'b10 |-> opnd_rt == exm_alu); // R2
    AST_MWB_RS_VALUE: assert property (@(posedge clk) disable iff (rst) sel_rs == 2'b01 |-> opnd_rs == mwb_data); // R3
    AST_MWB_RT_VALUE: assert property (@(posedge clk) disable iff (rst) sel_rt == 2'b01 |-> opnd_rt == mwb_data); // R3
    AST_RF_RS_VALUE: assert property (@(posedge clk) disable iff (rst) sel_rs == 2'b00 |-> opnd_rs == rf_rs_data); // R5
    AST_ZERO_RS: assert property (@(posedge clk) disable iff (rst) idex_rs == 5'd0 |-> sel_rs == 2'b00); // R5
    AST_ZERO_RT: assert property (@(posedge clk) disable iff (rst) idex_rt == 5'd0 |-> sel_rt == 2'b00); // R5
    AST_LEGAL_SEL: assert property (@(posedge clk) disable iff (rst) sel_rs != 2'b11 && sel_rt != 2'b11); // R7
    AST_ALU_NO_HOLD: assert property (@(posedge clk) disable iff (rst) !idex_ld |-> !hold_front); // R8
    AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (rst) hold_front |=> !hold_front); // R9
    AST_NOP_ENTERS: assert property (@(posedge clk) disable iff (rst) insert_nop |=> !idex_wr && !idex_ld); // R9
endmodule

bind bypass_ctrl bypass_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_rs     (sel_rs),
    .sel_rt     (sel_rt),
    .opnd_rs    (opnd_rs),
    .opnd_rt    (opnd_rt),
    .rf_rs_data (rf_rs_data),
    .rf_rt_data (rf_rt_data),
    .exm_alu    (exm_alu),
    .mwb_data   (mwb_data),
    .hold_front (hold_front),
    .insert_nop (insert_nop),
    .idex_rs    (idex_q.rs),
    .idex_rt    (idex_q.rt),
    .idex_wr    (idex_q.wr),
    .idex_ld    (idex_q.ld)
);

// File: tb/bypass_ctrl_bench.sv
module bypass_ctrl_bench;
    localparam int DW = 32;
    localparam logic [DW-1:0] RF_A = 32'h1111_1111;
    localparam logic [DW-1:0] RF_B = 32'h2222_2222;
    localparam logic [DW-1:0] EXV  = 32'hA5A5_0001;
    localparam logic [DW-1:0] MWV  = 32'h5A5A_0002;

    typedef struct packed {
        logic [4:0] rs, rt, dst;
        logic       wr, ld, urs, urt, hold;
        logic [1:0] srs, srt;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{5'd1,  5'd2,  5'd3,  1'b1,1'b0,1'b1,1'b1,1'b0,2'b00,2'b00},
        '{5'd3,  5'd5,  5'd4,  1'b1,1'b0,1'b1,1'b1,1'b0,2'b10,2'b00},
        '{5'd3,  5'd4,  5'd6,  1'b1,1'b0,1'b1,1'b1,1'b0,2'b01,2'b10},
        '{5'd4,  5'd4,  5'd7,  1'b1,1'b0,1'b1,1'b1,1'b0,2'b01,2'b01},
        '{5'd7,  5'd6,  5'd7,  1'b1,1'b0,1'b1,1'b1,1'b0,2'b10,2'b01},
        '{5'd7,  5'd0,  5'd7,  1'b1,1'b0,1'b1,1'b1,1'b0,2'b10,2'b00},
        '{5'd1,  5'd2,  5'd0,  1'b1,1'b0,1'b1,1'b1,1'b0,2'b00,2'b00},
        '{5'd0,  5'd0,  5'd8,  1'b1,1'b0,1'b1,1'b1,1'b0,2'b00,2'b00},
        '{5'd9,  5'd8,  5'd8,  1'b0,1'b0,1'b1,1'b1,1'b0,2'b00,2'b10},
        '{5'd8,  5'd9,  5'd10, 1'b1,1'b0,1'b1,1'b1,1'b0,2'b01,2'b00},
        '{5'd10, 5'd11, 5'd11, 1'b1,1'b1,1'b1,1'b0,1'b0,2'b10,2'b00},
        '{5'd11, 5'd1,  5'd12, 1'b1,1'b0,1'b1,1'b1,1'b1,2'b01,2'b00},
        '{5'd12, 5'd13, 5'd13, 1'b1,1'b1,1'b1,1'b0,1'b0,2'b10,2'b00},
        '{5'd1,  5'd2,  5'd14, 1'b1,1'b0,1'b1,1'b1,1'b0,2'b00,2'b00},
        '{5'd13, 5'd13, 5'd15, 1'b1,1'b0,1'b1,1'b1,1'b0,2'b01,2'b01},
        '{5'd15, 5'd16, 5'd16, 1'b1,1'b1,1'b1,1'b0,1'b0,2'b10,2'b00},
        '{5'd1,  5'd16, 5'd18, 1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,2'b10},
        '{5'd1,  5'd0,  5'd0,  1'b1,1'b1,1'b1,1'b0,1'b0,2'b00,2'b00},
        '{5'd0,  5'd0,  5'd19, 1'b1,1'b0,1'b1,1'b1,1'b0,2'b00,2'b00},
        '{5'd1,  5'd20, 5'd20, 1'b1,1'b1,1'b1,1'b0,1'b0,2'b00,2'b00},
        '{5'd2,  5'd20, 5'd21, 1'b1,1'b0,1'b1,1'b1,1'b1,2'b00,2'b01}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [4:0]    dec_rs = '0, dec_rt = '0, dec_dst = '0;
    logic          dec_wr = 1'b0, dec_load = 1'b0, dec_use_rs = 1'b0, dec_use_rt = 1'b0;
    logic [DW-1:0] rf_rs_data = RF_A, rf_rt_data = RF_B, exm_alu = EXV, mwb_data = MWV;
    logic [1:0]    sel_rs, sel_rt;
    logic [DW-1:0] opnd_rs, opnd_rt;
    logic          hold_front, insert_nop;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    bypass_ctrl #(.DATA_W(DW)) u_bypass_ctrl (
        .clk, .rst, .dec_rs, .dec_rt, .dec_dst, .dec_wr, .dec_load,
        .dec_use_rs, .dec_use_rt, .rf_rs_data, .rf_rt_data, .exm_alu,
        .mwb_data, .sel_rs, .sel_rt, .opnd_rs, .opnd_rt, .hold_front, .insert_nop
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] want(input logic [1:0] s, input logic [DW-1:0] rf);
        return (s == 2'b10) ? EXV : (s == 2'b01) ? MWV : rf;
    endfunction

    task automatic drive(input vec_t v);
        dec_rs = v.rs; dec_rt = v.rt; dec_dst = v.dst; dec_wr = v.wr;
        dec_load = v.ld; dec_use_rs = v.urs; dec_use_rt = v.urt;
    endtask

    // Row sits in execute: selects R2 R3 R4 R5 R6 R7 R11, operands by code
    task automatic check_ex(input int i);
        chk($sformatf("R2/R3/R4/R5/R6/R7/R11 row %0d sel_rs", i), DW'(sel_rs), DW'(TBL[i].srs));
        chk($sformatf("R2/R3/R4/R5/R6/R7/R11 row %0d sel_rt", i), DW'(sel_rt), DW'(TBL[i].srt));
        chk($sformatf("R2/R3/R5 row %0d opnd_rs", i), opnd_rs, want(TBL[i].srs, RF_A));
        chk($sformatf("R2/R3/R5 row %0d opnd_rt", i), opnd_rt, want(TBL[i].srt, RF_B));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset sel_rs", DW'(sel_rs), 0);
        chk("R1 reset sel_rt", DW'(sel_rt), 0);
        chk("R1 reset hold", DW'(hold_front), 0);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (i > 0) check_ex(i - 1);
            drive(TBL[i]);
            #1;
            chk($sformatf("R8/R9/R10/R11 row %0d hold", i), DW'(hold_front), DW'(TBL[i].hold));
            chk($sformatf("R9 row %0d nop", i), DW'(insert_nop), DW'(TBL[i].hold));
            if (TBL[i].hold) begin
                @(negedge clk);
                chk($sformatf("R9 row %0d bubble sel_rs", i), DW'(sel_rs), 0);
                chk($sformatf("R9 row %0d bubble sel_rt", i), DW'(sel_rt), 0);
                #1;
                chk($sformatf("R9 row %0d single hold", i), DW'(hold_front), 0);
            end
        end
        @(negedge clk);
        check_ex(NV - 1);

        // R1: reset mid-stream clears a pending load-use hold
        drive('{5'd1, 5'd22, 5'd22, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00});
        @(negedge clk);
        drive('{5'd22, 5'd3, 5'd23, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 2'b00});
        #1;
        chk("R9 pre-reset hold", DW'(hold_front), 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid reset hold", DW'(hold_front), 0);
        chk("R1 mid reset sel_rs", DW'(sel_rs), 0);
        chk("R1 mid reset sel_rt", DW'(sel_rt), 0);
        rst = 1'b0;
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #200us;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule